// File: doc/BRIEF.md
# Prefixed opcode stream decoder

This block takes instruction bytes one at a time, each qualified by a valid strobe, and recognises a small instruction group: subtract from the accumulator, test the accumulator by bitwise AND, and set the mixed-memory mode flag. Ahead of the opcode the stream may carry an optional size-suffix byte and an optional index-register byte. Behind the opcode it may carry a displacement byte or an immediate byte. Execution and memory access are left to other blocks.

For every complete instruction the decoder raises a one-clock completion strobe. With it, it presents the operation, the class of operand source, a register or index selector, the captured displacement or immediate, the size-suffix mode and the total cycle count. The set-mixed-memory instruction also raises a separate one-clock pulse. A byte that cannot continue a legal sequence raises an illegal pulse and sends the decoder back to idle.

Top module: `pfx_op_decoder`

## Requirements
- R1: After reset, all strobes (done, illegal, set-mix) are low, and op, src, sel, data, sfx and cycles read zero.
- R2: A lone byte 0x90–0x95 or 0x97 decodes as op=0 (subtract), src=0 (register), sel=low three opcode bits (B=0, C=1, D=2, E=3, H=4, L=5, A=7), cycles=1. The done strobe appears in the clock after the byte is accepted.
- R3: A lone 0x96 gives op=0, src=2 (indirect via HL), cycles=2. 0xD6 followed by byte n gives op=0, src=4 (immediate), data=n zero-extended, cycles=2.
- R4: Prefix 0xDD picks IX and 0xFD picks IY. A following 0x94 or 0x95 gives op=0, src=1 (index half) and cycles=2. sel bit1 is 1 for IY, and sel bit0 is 1 for the low half (0x95).
- R5: An index prefix, then 0x96, then byte d, gives op=0, src=3 (indexed), sel bit1 = IY, data=d sign-extended to the data width, cycles=4.
- R6: A leading 0x52 sets sfx=1 (short) and 0x49 sets sfx=2 (long). Either one adds one cycle. It is accepted only ahead of 0x96, an index prefix with 0x96 and d, or 0xED 0x34. Any other byte after it raises illegal.
- R7: 0xED 0x64 n gives op=1 (test), src=4, data=n, cycles=3. 0xED 0x34 gives op=1, src=2, cycles=3.
- R8: 0xED followed by 0x04, 0x0C, 0x14, 0x1C, 0x24, 0x2C or 0x3C gives op=1, src=0, sel=bits 5:3 of that byte (B through L as 0–5, A as 7), cycles=2.
- R9: 0xED 0x7D gives op=2 (set mixed-memory), src=5 (none), cycles=2. The set-mix pulse is high in exactly the clock that carries its done strobe.
- R10: A byte outside the legal set raises illegal for one clock in the cycle after that byte, with no done. The byte is consumed, and the next byte starts a new instruction.
- R11: done lasts one clock per instruction. data and cycles keep their values until the next completion.
- R12: While valid is low, the byte input is ignored and any partial prefix state is kept, so bytes of one instruction may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Instruction byte |
| done_o | output | 1 | One-clock completion strobe |
| illegal_o | output | 1 | One-clock illegal-sequence strobe |
| setmix_o | output | 1 | One-clock set-mixed-memory pulse |
| op_o | output | 2 | 0 subtract, 1 test, 2 set mixed-memory |
| src_o | output | 3 | 0 reg, 1 index half, 2 (HL), 3 indexed, 4 immediate, 5 none |
| sel_o | output | 3 | Register code or {0, IY, low-half} |
| data_o | output | DATA_W | Displacement (sign-extended) or immediate (zero-extended) |
| sfx_o | output | 2 | 0 none, 1 short, 2 long |
| cycles_o | output | CYC_W | Total cycle count |

## Verification
The assertions assume that reset is held with valid low, and that a byte counts only in a clock where valid is high. The rule that a strobe needs an accepted byte in the previous clock depends on that assumption. The stimulus drives valid and the byte only on falling edges. It keeps valid low during and right after reset. Its gaps toggle the byte lines only while valid is low, so every strobe comes from a byte the bench meant to deliver.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    typedef enum logic [1:0] {
        OP_SUB    = 2'd0,
        OP_TST    = 2'd1,
        OP_SETMIX = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        SRC_REG     = 3'd0,
        SRC_IDXHALF = 3'd1,
        SRC_IND_HL  = 3'd2,
        SRC_INDEXED = 3'd3,
        SRC_IMM     = 3'd4,
        SRC_NONE    = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        SFX_NONE  = 2'd0,
        SFX_SHORT = 2'd1,
        SFX_LONG  = 2'd2
    } sfx_e;

    typedef enum logic [1:0] {
        FOL_NONE = 2'd0,
        FOL_DISP = 2'd1,
        FOL_IMM  = 2'd2
    } fol_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_SFX  = 3'd1,
        S_IDX  = 3'd2,
        S_EXT  = 3'd3,
        S_WAIT = 3'd4
    } fsm_e;

    localparam int BASE_W = 3;

    typedef struct packed {
        logic              hit;
        op_e               op;
        src_e              src;
        logic [2:0]        sel;
        logic [BASE_W-1:0] base;
        fol_e              fol;
    } dec_t;

    localparam logic [7:0] B_SFX_SHORT = 8'h52;
    localparam logic [7:0] B_SFX_LONG  = 8'h49;
    localparam logic [7:0] B_IDX_X     = 8'hDD;
    localparam logic [7:0] B_IDX_Y     = 8'hFD;
    localparam logic [7:0] B_EXT       = 8'hED;

endpackage

// File: rtl/opdec_main_page.sv
module opdec_main_page
    import opdec_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       idx_i,
    input  logic       sfx_i,
    output dec_t       dec_o
);
    logic is_sub_reg;

    always_comb begin
        is_sub_reg = (byte_i[7:3] == 5'b10010) && (byte_i[2:0] != 3'd6);
        dec_o      = '0;
        if (!idx_i) begin
            if (is_sub_reg) begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_SUB;
                    dec_o.src  = SRC_REG;
                    dec_o.sel  = byte_i[2:0];
                    dec_o.base = BASE_W'(1);
                end
            end else if (byte_i == 8'h96) begin
                dec_o.hit  = 1'b1;
                dec_o.op   = OP_SUB;
                dec_o.src  = SRC_IND_HL;
                dec_o.base = BASE_W'(2);
            end else if (byte_i == 8'hD6) begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_SUB;
                    dec_o.src  = SRC_IMM;
                    dec_o.base = BASE_W'(2);
                    dec_o.fol  = FOL_IMM;
                end
            end
        end else begin
            if (byte_i == 8'h94 || byte_i == 8'h95) begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_SUB;
                    dec_o.src  = SRC_IDXHALF;
                    dec_o.sel  = {2'b00, byte_i[0]};
                    dec_o.base = BASE_W'(2);
                end
            end else if (byte_i == 8'h96) begin
                dec_o.hit  = 1'b1;
                dec_o.op   = OP_SUB;
                dec_o.src  = SRC_INDEXED;
                dec_o.base = BASE_W'(4);
                dec_o.fol  = FOL_DISP;
            end
        end
    end
endmodule

// File: rtl/opdec_ext_page.sv
module opdec_ext_page
    import opdec_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       sfx_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o = '0;
        case (byte_i)
            8'h04, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h2C, 8'h3C: begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_TST;
                    dec_o.src  = SRC_REG;
                    dec_o.sel  = byte_i[5:3];
                    dec_o.base = BASE_W'(2);
                end
            end
            8'h64: begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_TST;
                    dec_o.src  = SRC_IMM;
                    dec_o.base = BASE_W'(3);
                    dec_o.fol  = FOL_IMM;
                end
            end
            8'h34: begin
                dec_o.hit  = 1'b1;
                dec_o.op   = OP_TST;
                dec_o.src  = SRC_IND_HL;
                dec_o.base = BASE_W'(3);
            end
            8'h7D: begin
                if (!sfx_i) begin
                    dec_o.hit  = 1'b1;
                    dec_o.op   = OP_SETMIX;
                    dec_o.src  = SRC_NONE;
                    dec_o.base = BASE_W'(2);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfx_op_decoder.sv
module pfx_op_decoder
    import opdec_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              done_o,
    output logic              illegal_o,
    output logic              setmix_o,
    output logic [1:0]        op_o,
    output logic [2:0]        src_o,
    output logic [2:0]        sel_o,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        sfx_o,
    output logic [CYC_W-1:0]  cycles_o
);
    localparam int EXT_W = DATA_W - 8;

    typedef struct packed {
        fsm_e              st;
        sfx_e              sfx;
        logic              idx;
        logic              iy;
        op_e               p_op;
        src_e              p_src;
        logic [2:0]        p_sel;
        logic [CYC_W-1:0]  p_cyc;
        fol_e              p_fol;
        logic              done;
        logic              ill;
        logic              setmix;
        op_e               op;
        src_e              src;
        logic [2:0]        sel;
        logic [DATA_W-1:0] data;
        sfx_e              osfx;
        logic [CYC_W-1:0]  cyc;
    } st_t;

    st_t st_d, st_q;
    dec_t main_dec, ext_dec, cur_dec;

    opdec_main_page u_main (
        .byte_i (in_byte),
        .idx_i  (st_q.idx),
        .sfx_i  (st_q.sfx != SFX_NONE),
        .dec_o  (main_dec)
    );

    opdec_ext_page u_ext (
        .byte_i (in_byte),
        .sfx_i  (st_q.sfx != SFX_NONE),
        .dec_o  (ext_dec)
    );

    logic              take, fin, bad;
    op_e               f_op;
    src_e              f_src;
    logic [2:0]        f_sel;
    logic [CYC_W-1:0]  f_cyc;
    logic [DATA_W-1:0] f_data;
    logic [CYC_W-1:0]  t_cyc;
    logic [2:0]        t_sel;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.ill    = 1'b0;
        st_d.setmix = 1'b0;
        take   = 1'b0;
        fin    = 1'b0;
        bad    = 1'b0;
        f_op   = OP_SUB;
        f_src  = SRC_REG;
        f_sel  = '0;
        f_cyc  = '0;
        f_data = '0;
        cur_dec = (st_q.st == S_EXT) ? ext_dec : main_dec;
        t_cyc  = CYC_W'(cur_dec.base) + CYC_W'(st_q.sfx != SFX_NONE);
        t_sel  = st_q.idx ? {1'b0, st_q.iy, cur_dec.sel[0]} : cur_dec.sel;

        if (in_valid) begin
            case (st_q.st)
                S_IDLE, S_SFX: begin
                    if (st_q.st == S_IDLE &&
                        (in_byte == B_SFX_SHORT || in_byte == B_SFX_LONG)) begin
                        st_d.st  = S_SFX;
                        st_d.sfx = (in_byte == B_SFX_SHORT) ? SFX_SHORT : SFX_LONG;
                    end else if (in_byte == B_IDX_X || in_byte == B_IDX_Y) begin
                        st_d.st  = S_IDX;
                        st_d.idx = 1'b1;
                        st_d.iy  = (in_byte == B_IDX_Y);
                    end else if (in_byte == B_EXT) begin
                        st_d.st = S_EXT;
                    end else begin
                        take = 1'b1;
                    end
                end
                S_IDX, S_EXT: take = 1'b1;
                S_WAIT: begin
                    fin    = 1'b1;
                    f_op   = st_q.p_op;
                    f_src  = st_q.p_src;
                    f_sel  = st_q.p_sel;
                    f_cyc  = st_q.p_cyc;
                    f_data = (st_q.p_fol == FOL_DISP) ?
                             {{EXT_W{in_byte[7]}}, in_byte} :
                             {{EXT_W{1'b0}}, in_byte};
                end
                default: bad = 1'b1;
            endcase
        end

        if (take) begin
            if (!cur_dec.hit) begin
                bad = 1'b1;
            end else if (cur_dec.fol == FOL_NONE) begin
                fin   = 1'b1;
                f_op  = cur_dec.op;
                f_src = cur_dec.src;
                f_sel = t_sel;
                f_cyc = t_cyc;
            end else begin
                st_d.st    = S_WAIT;
                st_d.p_op  = cur_dec.op;
                st_d.p_src = cur_dec.src;
                st_d.p_sel = t_sel;
                st_d.p_cyc = t_cyc;
                st_d.p_fol = cur_dec.fol;
            end
        end

        if (fin) begin
            st_d.done   = 1'b1;
            st_d.setmix = (f_op == OP_SETMIX);
            st_d.op     = f_op;
            st_d.src    = f_src;
            st_d.sel    = f_sel;
            st_d.data   = f_data;
            st_d.osfx   = st_q.sfx;
            st_d.cyc    = f_cyc;
        end
        if (fin || bad) begin
            st_d.st  = S_IDLE;
            st_d.sfx = SFX_NONE;
            st_d.idx = 1'b0;
            st_d.iy  = 1'b0;
        end
        if (bad) st_d.ill = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o    = st_q.done;
    assign illegal_o = st_q.ill;
    assign setmix_o  = st_q.setmix;
    assign op_o      = st_q.op;
    assign src_o     = st_q.src;
    assign sel_o     = st_q.sel;
    assign data_o    = st_q.data;
    assign sfx_o     = st_q.osfx;
    assign cycles_o  = st_q.cyc;

    AST_DONE_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o)); // R10
    AST_SETMIX_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        setmix_o |-> (done_o && op_o == 2'd2)); // R9
    AST_SFX_FORMS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sfx_o != 2'd0) |-> (src_o == 3'd2 || src_o == 3'd3)); // R6
    AST_NEED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !(done_o || illegal_o)); // R12
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(data_o) && $stable(cycles_o))); // R11
    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o >= CYC_W'(1) && cycles_o <= CYC_W'(5))); // R2
    AST_REG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && src_o == 3'd0) |-> (sel_o != 3'd6)); // R8

endmodule

// File: tb/pfx_op_decoder_test.sv
module pfx_op_decoder_test;
    localparam int DW = 24;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          done_o, illegal_o, setmix_o;
    logic [1:0]    op_o, sfx_o;
    logic [2:0]    src_o, sel_o;
    logic [DW-1:0] data_o;
    logic [CW-1:0] cycles_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    typedef struct {
        bit          ill;
        int          op;
        int          src;
        int          sel;
        logic [DW-1:0] data;
        int          sfx;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    pfx_op_decoder #(.DATA_W(DW), .CYC_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .done_o(done_o), .illegal_o(illegal_o), .setmix_o(setmix_o),
        .op_o(op_o), .src_o(src_o), .sel_o(sel_o), .data_o(data_o),
        .sfx_o(sfx_o), .cycles_o(cycles_o)
    );

    task automatic exp_ok(input int op, input int src, input int sel,
                          input logic [DW-1:0] data, input int sfx,
                          input int cyc, input string tag);
        exp_t e;
        e.ill = 0; e.op = op; e.src = src; e.sel = sel; e.data = data;
        e.sfx = sfx; e.cyc = cyc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_bad(input string tag);
        exp_t e;
        e.ill = 1; e.op = 0; e.src = 0; e.sel = 0; e.data = '0;
        e.sfx = 0; e.cyc = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
    endtask

    task automatic gap(input int n, input logic [7:0] junk);
        in_valid = 1'b0;
        in_byte  = junk;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: pop scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && (done_o || illegal_o)) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10/R12 unexpected strobe: actual done=%0d ill=%0d expected none",
                         done_o, illegal_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.ill) begin
                    if (!(illegal_o && !done_o && !setmix_o)) begin
                        fails++;
                        $display("FAIL %s: actual done=%0d ill=%0d expected done=0 ill=1",
                                 e.tag, done_o, illegal_o);
                    end
                end else if (!(done_o && !illegal_o && int'(op_o) == e.op &&
                               int'(src_o) == e.src && int'(sel_o) == e.sel &&
                               data_o == e.data && int'(sfx_o) == e.sfx &&
                               int'(cycles_o) == e.cyc &&
                               setmix_o == (e.op == 2))) begin
                    fails++;
                    $display("FAIL %s: actual done=%0d ill=%0d op=%0d src=%0d sel=%0d data=%h sfx=%0d cyc=%0d mix=%0d expected op=%0d src=%0d sel=%0d data=%h sfx=%0d cyc=%0d",
                             e.tag, done_o, illegal_o, op_o, src_o, sel_o, data_o, sfx_o,
                             cycles_o, setmix_o, e.op, e.src, e.sel, e.data, e.sfx, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual run still active expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        checks++;
        if (done_o || illegal_o || setmix_o || op_o != 0 || src_o != 0 || sel_o != 0 ||
            data_o != 0 || sfx_o != 0 || cycles_o != 0) begin
            fails++;
            $display("FAIL R1: actual done=%0d ill=%0d mix=%0d data=%h cyc=%0d expected all zero",
                     done_o, illegal_o, setmix_o, data_o, cycles_o);
        end

        // R2 single-byte subtract from register, back to back
        for (int i = 0; i < 8; i++) begin
            if (i != 6) begin
                exp_ok(0, 0, i, '0, 0, 1, "R2");
                put(8'h90 + 8'(i));
            end
        end

        // R3 indirect and immediate
        exp_ok(0, 2, 0, '0, 0, 2, "R3");
        put(8'h96);
        exp_ok(0, 4, 0, 24'h0000A5, 0, 2, "R3");
        put(8'hD6); put(8'hA5);

        // R11 outputs hold after the one-clock strobe
        gap(1, 8'h00);
        checks++;
        if (done_o || data_o != 24'h0000A5 || cycles_o != 2) begin
            fails++;
            $display("FAIL R11: actual done=%0d data=%h cyc=%0d expected done=0 data=0000a5 cyc=2",
                     done_o, data_o, cycles_o);
        end

        // R4 index halves
        exp_ok(0, 1, 0, '0, 0, 2, "R4"); put(8'hDD); put(8'h94);
        exp_ok(0, 1, 1, '0, 0, 2, "R4"); put(8'hDD); put(8'h95);
        exp_ok(0, 1, 2, '0, 0, 2, "R4"); put(8'hFD); put(8'h94);
        exp_ok(0, 1, 3, '0, 0, 2, "R4"); put(8'hFD); put(8'h95);

        // R5 indexed with displacement, sign extension
        exp_ok(0, 3, 0, 24'h000005, 0, 4, "R5"); put(8'hDD); put(8'h96); put(8'h05);
        exp_ok(0, 3, 2, 24'hFFFFF0, 0, 4, "R5"); put(8'hFD); put(8'h96); put(8'hF0);
        exp_ok(0, 3, 0, 24'hFFFF80, 0, 4, "R5"); put(8'hDD); put(8'h96); put(8'h80);

        // R6 suffix forms and misuse
        exp_ok(0, 2, 0, '0, 1, 3, "R6"); put(8'h52); put(8'h96);
        exp_ok(0, 3, 2, 24'hFFFF80, 2, 5, "R6"); put(8'h49); put(8'hFD); put(8'h96); put(8'h80);
        exp_ok(1, 2, 0, '0, 1, 4, "R6"); put(8'h52); put(8'hED); put(8'h34);
        exp_bad("R6"); put(8'h49); put(8'h90);
        exp_bad("R6"); put(8'h52); put(8'hD6);
        exp_bad("R6"); put(8'h52); put(8'hDD); put(8'h94);

        // R7 test immediate and indirect
        exp_ok(1, 4, 0, 24'h00003C, 0, 3, "R7"); put(8'hED); put(8'h64); put(8'h3C);
        exp_ok(1, 2, 0, '0, 0, 3, "R7"); put(8'hED); put(8'h34);

        // R8 test against register
        for (int i = 0; i < 8; i++) begin
            if (i != 6) begin
                exp_ok(1, 0, i, '0, 0, 2, "R8");
                put(8'hED); put(8'(i << 3) | 8'h04);
            end
        end

        // R9 set mixed-memory flag
        exp_ok(2, 5, 0, '0, 0, 2, "R9"); put(8'hED); put(8'h7D);

        // R10 illegal sequences, then fresh decode
        exp_bad("R10"); put(8'hED); put(8'h96);
        exp_bad("R10"); put(8'hDD); put(8'hDD);
        exp_bad("R10"); put(8'h00);
        exp_ok(0, 0, 7, '0, 0, 1, "R10"); put(8'h97);

        // R12 gaps with junk on the byte lines
        exp_ok(0, 3, 2, 24'h00007F, 0, 4, "R12");
        put(8'hFD);
        gap(3, 8'h00);
        put(8'h96);
        gap(2, 8'hED);
        put(8'h7F);

        gap(4, 8'h00);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11: actual %0d outstanding results expected 0", sb.size());
        end
        finish_run();
    end
endmodule